// File: doc/BRIEF.md
# Dual-Rail Half-Buffer Handshake Pipeline

This block is a chain of handshake stages that passes one bit per token. Each bit travels on a pair of rails. The pair (rail1, rail0) = 2'b01 carries logic 0, 2'b10 carries logic 1, and 2'b00 is the empty (spacer) code that must sit between any two tokens. There is no separate request wire: a valid code on a channel is the request. Each channel uses a four-phase handshake. Data becomes valid, the receiver acknowledges, the sender returns to the spacer, and the receiver releases the acknowledge. Only then may the next token follow.

Each stage stores its two rails in Muller C-elements. One input of each C-element is the incoming rail, and the other is the acknowledge that comes back from the next stage. A completion detector on the stage output makes the acknowledge that goes upstream. That acknowledge is low while the stage holds a valid code and high while it holds the spacer. The model advances in discrete steps on a simulation clock, so it can be synthesized. Every stage has a stall input that freezes it for a cycle, which stands in for an unpredictable gate delay. A sink drives `out_ack` high when it is ready for data and low once it has taken a token.

Top module: `dr_wchb_pipe`

## Requirements
- R1: Every rail pair inside the pipeline and on `out_data` is always 2'b01 (logic 0), 2'b10 (logic 1) or 2'b00 (spacer). The code 2'b11 never appears.
- R2: A synchronous active-low reset clears every C-element to 0. After reset, `out_data` is 2'b00 and `in_ack` is 1.
- R3: `in_ack` is 0 while the first stage holds a valid code and 1 while it holds the spacer. The first clock edge that captures a token drops `in_ack`.
- R4: A stage moves from spacer to a valid code only on an edge where the acknowledge from its downstream neighbour is high. It returns from a valid code to the spacer only on an edge where that acknowledge is low. While the sink keeps `out_ack` high, the output token stays in place and later tokens queue behind it.
- R5: While `stall[i]` is high at a clock edge, stage i (stage 0 takes `in_data`) keeps its rails unchanged, whatever its inputs are.
- R6: Every token reaches `out_data` exactly once, in the order it entered, for any pattern of stalls and sink delays.
- R7: A stage that holds a valid code never switches straight to a different valid code. The spacer always comes between two tokens.
- R8: With no stall and a sink ready, a token driven onto `in_data` appears on `out_data` after NUM_STAGES clock edges, one stage per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Simulation clock that steps all C-elements |
| rst_n | input | 1 | Synchronous active-low reset to spacer |
| stall | input | NUM_STAGES | Per-stage freeze; bit i holds stage i for one edge |
| in_data | input | 2 | Input channel rails {rail1, rail0} |
| in_ack | output | 1 | Acknowledge to the source; low while stage 0 holds a token |
| out_data | output | 2 | Output channel rails {rail1, rail0} from the last stage |
| out_ack | input | 1 | Acknowledge from the sink; high means ready for a token |

## Verification
The hardest state to reach is a full pipeline: one token held at the output by a sink that will not acknowledge, a second token waiting behind it with a spacer between them, and then a release of the sink. This tests that the spacer is captured only when the acknowledge is low and that the waiting token moves forward only afterwards. A directed sequence holds `out_ack` high while it pushes a second token in, and then releases it. Random stall patterns on each stage and random sink delays then drive 1000 random-valued tokens. This produces uneven stage timings, and the output order is compared with the order of the tokens sent.

// File: rtl/dr_pipe_pkg.sv
package dr_pipe_pkg;

  typedef logic [1:0] dr_t;

  localparam dr_t DR_EMPTY = 2'b00;
  localparam dr_t DR_ZERO  = 2'b01;
  localparam dr_t DR_ONE   = 2'b10;

  // Muller C-element next state: follow when inputs agree, else keep
  function automatic logic c_next(input logic a, input logic b, input logic q);
    if (a && b)        return 1'b1;
    else if (!a && !b) return 1'b0;
    else               return q;
  endfunction

  // completion detect: high only when both rails are low (spacer held)
  function automatic logic empty_ack(input dr_t r);
    return ~(r[1] | r[0]);
  endfunction

endpackage

// File: rtl/dr_celem.sv
module dr_celem
  import dr_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic a,
  input  logic b,
  output logic q
);

  always_ff @(posedge clk) begin
    if (!rst_n)     q <= 1'b0;
    else if (!hold) q <= c_next(a, b, q);
  end

endmodule

// File: rtl/dr_stage.sv
module dr_stage
  import dr_pipe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  dr_t  rail_in,
  input  logic ack_dn,
  output dr_t  rail_q,
  output logic ack_up
);

  for (genvar j = 0; j < 2; j++) begin : g_rail
    dr_celem u_c (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (hold),
      .a    (rail_in[j]),
      .b    (ack_dn),
      .q    (rail_q[j])
    );
  end

  assign ack_up = empty_ack(rail_q);

endmodule

// File: rtl/dr_wchb_pipe.sv
module dr_wchb_pipe
  import dr_pipe_pkg::*;
#(
  parameter int NUM_STAGES = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_STAGES-1:0] stall,
  input  logic [1:0]            in_data,
  output logic                  in_ack,
  output logic [1:0]            out_data,
  input  logic                  out_ack
);

  localparam int LAST = NUM_STAGES - 1;

  // named internal events, visible to the bound checker
  logic [NUM_STAGES-1:0][1:0] stage_q;
  logic [NUM_STAGES-1:0][1:0] rail_in;
  logic [NUM_STAGES-1:0]      ack_up;
  logic [NUM_STAGES-1:0]      ack_nxt;

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign rail_in[i] = in_data;
    end else begin : g_body
      assign rail_in[i] = stage_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign ack_nxt[i] = out_ack;
    end else begin : g_link
      assign ack_nxt[i] = ack_up[i+1];
    end

    dr_stage u_stage (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (stall[i]),
      .rail_in(rail_in[i]),
      .ack_dn (ack_nxt[i]),
      .rail_q (stage_q[i]),
      .ack_up (ack_up[i])
    );
  end

  assign in_ack   = ack_up[0];
  assign out_data = stage_q[LAST];

endmodule

// File: rtl/dr_wchb_chk.sv
module dr_wchb_chk #(
  parameter int NUM_STAGES = 3
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_STAGES-1:0]      stall,
  input logic [1:0]                 in_data,
  input logic [NUM_STAGES-1:0][1:0] stage_q,
  input logic [NUM_STAGES-1:0]      ack_nxt
);

  // R1
  in_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_data != 2'b11);

  for (genvar i = 0; i < NUM_STAGES; i++) begin : g_chk
    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stage_q[i] != 2'b11);

    // R4
    fill_when_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stage_q[i]) == 2'b00 && stage_q[i] != 2'b00) |-> $past(ack_nxt[i]));

    // R4
    drain_when_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(stage_q[i]) != 2'b00 && stage_q[i] == 2'b00) |-> !$past(ack_nxt[i]));

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall[i] |=> $stable(stage_q[i]));

    // R7
    spacer_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stage_q[i] != 2'b00) |=> (stage_q[i] == $past(stage_q[i]) || stage_q[i] == 2'b00));
  end

endmodule

bind dr_wchb_pipe dr_wchb_chk #(.NUM_STAGES(NUM_STAGES)) chk_i (
  .clk    (clk),
  .rst_n  (rst_n),
  .stall  (stall),
  .in_data(in_data),
  .stage_q(stage_q),
  .ack_nxt(ack_nxt)
);

// File: tb/dr_wchb_pipe_tb_top.sv
`timescale 1ns/1ps
module dr_wchb_pipe_tb_top;

  localparam int NS   = 3;
  localparam int NTOK = 1000;
  localparam int MAXCYC = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] stall = '0;
  logic [1:0]    in_data = 2'b00;
  logic          in_ack;
  logic [1:0]    out_data;
  logic          out_ack = 1'b1;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dr_wchb_pipe #(.NUM_STAGES(NS)) dut_i (
    .clk(clk), .rst_n(rst_n), .stall(stall), .in_data(in_data),
    .in_ack(in_ack), .out_data(out_data), .out_ack(out_ack)
  );

  function automatic logic [1:0] enc(input bit b);
    return b ? 2'b10 : 2'b01;
  endfunction

  function automatic bit is_tok(input logic [1:0] r);
    return (r == 2'b01) || (r == 2'b10);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic do_reset();
    stall = '0; in_data = 2'b00; out_ack = 1'b1; rst_n = 1'b0;
    tick(2);
    rst_n = 1'b1;
  endtask

  bit exp_q [NTOK];

  initial begin
    int sent, recv, cyc;
    bit got;
    logic [1:0] last_tok;
    bit s;

    void'($urandom(32'h5EED_0042));
    do_reset();
    chk("R2 out_data after reset", out_data, 2'b00);
    chk("R2 in_ack after reset", in_ack, 1);

    // R8 / R3 latency, free flow
    in_data = 2'b10;
    tick(1);
    chk("R3 in_ack low after capture", in_ack, 0);
    chk("R8 not yet at output (1 edge)", out_data, 2'b00);
    tick(1);
    chk("R8 not yet at output (2 edges)", out_data, 2'b00);
    tick(1);
    chk("R8 token at output after 3 edges", out_data, 2'b10);

    // R4 backpressure: sink never acknowledges
    in_data = 2'b00;
    tick(4);
    chk("R3 in_ack high after spacer", in_ack, 1);
    in_data = 2'b01;
    tick(8);
    chk("R4 output held while out_ack high", out_data, 2'b10);
    chk("R4 second token waits in stage 0", in_ack, 0);
    out_ack = 1'b0;
    tick(1);
    chk("R4 spacer taken when out_ack low", out_data, 2'b00);
    out_ack = 1'b1;
    tick(1);
    chk("R7 spacer kept one more edge", out_data, 2'b00);
    tick(1);
    chk("R6 queued token arrives in order", out_data, 2'b01);

    // R5 stall directed
    do_reset();
    chk("R2 reset mid-run clears output", out_data, 2'b00);
    stall = 3'b100;
    in_data = 2'b10;
    tick(6);
    chk("R5 stalled last stage holds spacer", out_data, 2'b00);
    stall = 3'b000;
    tick(1);
    chk("R5 released stage captures", out_data, 2'b10);

    // random phase
    do_reset();
    sent = 0; recv = 0; cyc = 0; last_tok = 2'b00;
    while (recv < NTOK && cyc < MAXCYC) begin
      // sample (we are just after a negedge)
      if (out_data == 2'b11) chk("R1 illegal code", out_data, 2'b00);
      if (out_ack && is_tok(out_data)) begin
        if ($urandom % 3 != 0) begin
          got = (out_data == 2'b10);
          if (recv < sent) chk("R6 token order", got, exp_q[recv]);
          else chk("R6 extra token", 1, 0);
          last_tok = out_data;
          recv++;
          out_ack = 1'b0;
        end
      end else if (!out_ack && is_tok(out_data)) begin
        if (out_data != last_tok) chk("R7 token changed without spacer", out_data, last_tok);
      end else if (!out_ack && out_data == 2'b00) begin
        if ($urandom % 3 != 0) out_ack = 1'b1;
      end
      if (in_data == 2'b00 && in_ack && sent < NTOK) begin
        if ($urandom % 2 == 0) begin
          s = 1'($urandom);
          exp_q[sent] = s;
          in_data = enc(s);
          sent++;
        end
      end else if (is_tok(in_data) && !in_ack) begin
        in_data = 2'b00;
      end
      for (int i = 0; i < NS; i++) stall[i] = ($urandom % 4 == 0);
      tick(1);
      cyc++;
    end
    stall = '0;
    chk("R6 all tokens delivered", recv, NTOK);
    chk("R6 all tokens sent", sent, NTOK);
    if (cyc >= MAXCYC) chk("R6 watchdog (loop)", 0, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule